// File: doc/BRIEF.md
# Triggered Waveform Playback Controller

This block keeps up to four sample waveforms in an on-chip sample memory and streams one of them to a DAC when a trigger arrives. A host loads waves through a word-wide command port. A header word picks a wave slot. A count word sets how many points the slot holds. Sample words then fill the slot in order. A separate select word chooses the slot that the next trigger will play.

Each slot owns a fixed quarter of the sample memory and a length register. Once triggered, the player reads the selected slot from point zero. Each sample is held for a programmable number of clocks. After the last point the player wraps back to point zero with no gap. It keeps running until it is stopped or triggered again. The host may load other slots while playback runs. Count and sample words aimed at the slot on air are held off with a ready signal, so a playing wave is never altered mid-stream.

Top module: `wpb_top`

## Requirements
- R1: After reset `dac_out` is 0, `dac_valid` is 0, `playing` is 0 and `host_ready` is 1. Every slot length is 0 and slot 0 is selected.
- R2: Host words are decoded from `host_kind`: 0 header (slot in `host_data[1:0]`), 1 count (points in `host_data`), 2 sample, 3 select (slot in `host_data[1:0]`). A count word sets the slot length and rewinds the write position to point 0. Each accepted sample word is stored at the next point of the slot. Sample words beyond the count are dropped.
- R3: When `trigger` is sampled high at a clock edge and the selected slot has nonzero length, `dac_out` shows point 0 of that slot and `dac_valid` is high right after that same edge.
- R4: Each sample stays on `dac_out` for `hold_clks`+1 clocks. `dac_valid` is high only in the first clock of each new sample.
- R5: After the last point of the wave, point 0 follows with the same spacing as any other step, and the sequence repeats.
- R6: A select word changes only which slot the next trigger plays. The current playback continues undisturbed.
- R7: `stop` sampled high drives `dac_out` to 0, `dac_valid` to 0 and `playing` to 0 after that edge. Stop wins over a trigger in the same clock.
- R8: A trigger on a slot of length 0 leaves the block idle with `dac_out` at 0.
- R9: While a slot plays, count and sample words that target that slot see `host_ready` low and have no effect. Words for other slots are accepted.
- R10: A trigger during playback restarts at point 0 of the currently selected slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host word present |
| host_kind | input | 2 | Host word type: 0 header, 1 count, 2 sample, 3 select |
| host_data | input | 16 | Host word payload |
| host_ready | output | 1 | Host word accepted this clock |
| trigger | input | 1 | Start playback of the selected slot |
| stop | input | 1 | End playback and zero the output |
| hold_clks | input | 16 | Extra clocks each sample is held |
| dac_out | output | 16 | Sample to the DAC |
| dac_valid | output | 1 | One-clock strobe per new sample |
| playing | output | 1 | Playback active |

## Verification
The bench checks the wrap from the last point back to point zero, including a one-point wave and waves with several hold settings. A design with an off-by-one index limit would repeat a point or skip point zero there. It attempts a sample write into the slot on air and then replays that slot. A missing hold-off would show the foreign word in the stream. It over-fills a slot and then shrinks and regrows its length, which exposes a write pointer that ignores the count. It also drives stop and trigger together, so a design that gives priority to the trigger would keep playing.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
    typedef enum logic [1:0] {
        KIND_HEAD   = 2'd0,
        KIND_COUNT  = 2'd1,
        KIND_SAMPLE = 2'd2,
        KIND_SELECT = 2'd3
    } host_kind_e;

    typedef enum logic {
        PB_IDLE = 1'b0,
        PB_RUN  = 1'b1
    } pb_state_e;
endpackage

// File: rtl/wpb_sample_ram.sv
module wpb_sample_ram #(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [2**AW];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/wpb_slot_table.sv
module wpb_slot_table #(
    parameter int SLOTS = 4,
    parameter int LEN_W = 11,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SW-1:0]    wr_slot,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [SW-1:0]    rd_a_slot,
    output logic [LEN_W-1:0] rd_a_len,
    input  logic [SW-1:0]    rd_b_slot,
    output logic [LEN_W-1:0] rd_b_len
);
    logic [LEN_W-1:0] len_d [SLOTS];
    logic [LEN_W-1:0] len_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_comb begin
            len_d[g] = len_q[g];
            if (wr_en && wr_slot == SW'(g)) len_d[g] = wr_len;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) len_q[g] <= '0;
            else        len_q[g] <= len_d[g];
        end
    end

    assign rd_a_len = len_q[rd_a_slot];
    assign rd_b_len = len_q[rd_b_slot];
endmodule

// File: rtl/wpb_player.sv
module wpb_player
    import wpb_pkg::*;
#(
    parameter int AW     = 12,
    parameter int SLOTS  = 4,
    parameter int HOLD_W = 16,
    localparam int SW    = $clog2(SLOTS),
    localparam int IW    = AW - SW,
    localparam int LEN_W = IW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trigger,
    input  logic              stop,
    input  logic [SW-1:0]     sel_slot,
    input  logic [LEN_W-1:0]  sel_len,
    input  logic [HOLD_W-1:0] hold_clks,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    output logic              sample_strobe,
    output logic              playing,
    output logic [SW-1:0]     play_slot
);
    typedef struct packed {
        pb_state_e         state;
        logic [SW-1:0]     slot;
        logic [LEN_W-1:0]  len;
        logic [IW-1:0]     idx;
        logic [HOLD_W-1:0] cnt;
        logic              strobe;
    } pb_t;

    pb_t pb_d, pb_q;
    logic [IW-1:0] idx_next;

    always_comb begin
        pb_d     = pb_q;
        pb_d.strobe = 1'b0;
        idx_next = ({1'b0, pb_q.idx} == pb_q.len - LEN_W'(1)) ? '0 : pb_q.idx + IW'(1);
        rd_en    = 1'b0;
        rd_addr  = {pb_q.slot, idx_next};
        if (stop) begin
            pb_d.state = PB_IDLE;
        end else if (trigger) begin
            if (sel_len == '0) begin
                pb_d.state = PB_IDLE;
            end else begin
                pb_d.state  = PB_RUN;
                pb_d.slot   = sel_slot;
                pb_d.len    = sel_len;
                pb_d.idx    = '0;
                pb_d.cnt    = hold_clks;
                pb_d.strobe = 1'b1;
                rd_en       = 1'b1;
                rd_addr     = {sel_slot, {IW{1'b0}}};
            end
        end else if (pb_q.state == PB_RUN) begin
            if (pb_q.cnt == '0) begin
                pb_d.cnt    = hold_clks;
                pb_d.idx    = idx_next;
                pb_d.strobe = 1'b1;
                rd_en       = 1'b1;
            end else begin
                pb_d.cnt = pb_q.cnt - HOLD_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pb_q <= '{state: PB_IDLE, default: '0};
        else        pb_q <= pb_d;
    end

    assign sample_strobe = pb_q.strobe;
    assign playing       = (pb_q.state == PB_RUN);
    assign play_slot     = pb_q.slot;

    assert_trigger_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trigger && !stop && sel_len != '0 |=> playing && sample_strobe && pb_q.idx == '0);

    assert_strobe_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe && $past(hold_clks) != '0 && !trigger && !stop |=> !sample_strobe);

    assert_stop_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !playing && !sample_strobe);

    assert_empty_slot_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trigger && !stop && sel_len == '0 |=> !playing);

    assert_strobe_only_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> playing);
endmodule

// File: rtl/wpb_top.sv
module wpb_top
    import wpb_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 12,
    parameter int SLOTS  = 4,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [1:0]        host_kind,
    input  logic [DW-1:0]     host_data,
    output logic              host_ready,
    input  logic              trigger,
    input  logic              stop,
    input  logic [HOLD_W-1:0] hold_clks,
    output logic [DW-1:0]     dac_out,
    output logic              dac_valid,
    output logic              playing
);
    localparam int SW    = $clog2(SLOTS);
    localparam int IW    = AW - SW;
    localparam int LEN_W = IW + 1;
    localparam int DEPTH = 2 ** IW;

    typedef struct packed {
        logic [SW-1:0]    load_slot;
        logic [LEN_W-1:0] wr_ptr;
        logic [SW-1:0]    sel;
    } host_t;

    host_t hs_d, hs_q;
    host_kind_e kind;
    logic             conflict, accept;
    logic             tbl_we;
    logic [LEN_W-1:0] tbl_len;
    logic [LEN_W-1:0] load_len, sel_len;
    logic             ram_we;
    logic [AW-1:0]    ram_waddr;
    logic             rd_en;
    logic [AW-1:0]    rd_addr;
    logic [DW-1:0]    rd_data;
    logic [SW-1:0]    play_slot;
    logic             strobe;

    assign kind = host_kind_e'(host_kind);

    always_comb begin
        hs_d      = hs_q;
        conflict  = host_valid && (kind == KIND_COUNT || kind == KIND_SAMPLE)
                    && playing && hs_q.load_slot == play_slot;
        accept    = host_valid && !conflict;
        tbl_we    = 1'b0;
        tbl_len   = (32'(host_data) > DEPTH) ? LEN_W'(DEPTH) : host_data[LEN_W-1:0];
        ram_we    = 1'b0;
        ram_waddr = {hs_q.load_slot, hs_q.wr_ptr[IW-1:0]};
        if (accept) begin
            case (kind)
                KIND_HEAD:   hs_d.load_slot = host_data[SW-1:0];
                KIND_COUNT: begin
                    tbl_we      = 1'b1;
                    hs_d.wr_ptr = '0;
                end
                KIND_SAMPLE: begin
                    if (hs_q.wr_ptr < load_len) begin
                        ram_we      = 1'b1;
                        hs_d.wr_ptr = hs_q.wr_ptr + LEN_W'(1);
                    end
                end
                default:     hs_d.sel = host_data[SW-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign host_ready = !conflict;

    wpb_slot_table #(.SLOTS(SLOTS), .LEN_W(LEN_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_slot  (hs_q.load_slot),
        .wr_len   (tbl_len),
        .rd_a_slot(hs_q.load_slot),
        .rd_a_len (load_len),
        .rd_b_slot(hs_q.sel),
        .rd_b_len (sel_len)
    );

    wpb_sample_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(host_data),
        .re   (rd_en),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    wpb_player #(.AW(AW), .SLOTS(SLOTS), .HOLD_W(HOLD_W)) u_player (
        .clk          (clk),
        .rst_n        (rst_n),
        .trigger      (trigger),
        .stop         (stop),
        .sel_slot     (hs_q.sel),
        .sel_len      (sel_len),
        .hold_clks    (hold_clks),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .sample_strobe(strobe),
        .playing      (playing),
        .play_slot    (play_slot)
    );

    assign dac_out   = playing ? rd_data : '0;
    assign dac_valid = strobe;

    assert_no_write_into_live_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we && playing |-> ram_waddr[AW-1 -: SW] != play_slot);

    assert_read_only_when_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> playing);
endmodule

// File: tb/tb_wpb_top.sv
`timescale 1ns/100ps
module tb_wpb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [1:0]  host_kind = 2'd0;
    logic [15:0] host_data = '0;
    logic        host_ready;
    logic        trigger = 1'b0;
    logic        stop = 1'b0;
    logic [15:0] hold_clks = '0;
    logic [15:0] dac_out;
    logic        dac_valid;
    logic        playing;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wpb_top dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_kind(host_kind),
        .host_data(host_data), .host_ready(host_ready), .trigger(trigger), .stop(stop),
        .hold_clks(hold_clks), .dac_out(dac_out), .dac_valid(dac_valid), .playing(playing)
    );

    typedef struct packed {
        logic [1:0] slot;
        logic [7:0] len;
        logic [3:0] hold;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{slot: 2'd0, len: 8'd5, hold: 4'd0},
        '{slot: 2'd1, len: 8'd3, hold: 4'd2},
        '{slot: 2'd2, len: 8'd1, hold: 4'd1},
        '{slot: 2'd3, len: 8'd4, hold: 4'd3}
    };

    function automatic logic [15:0] wave(int s, int i, int salt);
        return 16'((s + 1) * 4096 + salt * 256 + i * 3 + 1);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(int kind, int data);
        host_valid = 1'b1;
        host_kind  = 2'(kind);
        host_data  = 16'(data);
        #1;
        while (!host_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic load(int s, int len, int salt);
        send(0, s);
        send(1, len);
        for (int i = 0; i < len; i++) send(2, wave(s, i, salt));
    endtask

    task automatic pulse_trigger();
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
    endtask

    task automatic play_check(int s, int len, int hold, int salt);
        for (int k = 0; k < 2 * len; k++) begin
            if (k == 0) check("R3 first point", dac_out, wave(s, 0, salt));
            else        check("R5 sequence/wrap", dac_out, wave(s, k % len, salt));
            check("R4 strobe on new sample", 16'(dac_valid), 16'd1);
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check("R4 held sample", dac_out, wave(s, k % len, salt));
                check("R4 strobe low while held", 16'(dac_valid), 16'd0);
            end
            @(negedge clk);
        end
    endtask

    task automatic check_idle(string req);
        check(req, dac_out, 16'd0);
        check(req, 16'(dac_valid), 16'd0);
        check(req, 16'(playing), 16'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset outputs");
        #1;
        check("R1 ready after reset", 16'(host_ready), 16'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: slot 2 is still empty
        send(3, 2);
        pulse_trigger();
        check_idle("R8 empty slot trigger");

        // table-driven playback of every slot
        foreach (VECS[v]) begin
            load(int'(VECS[v].slot), int'(VECS[v].len), 0);
            hold_clks = 16'(VECS[v].hold);
            send(3, int'(VECS[v].slot));
            pulse_trigger();
            play_check(int'(VECS[v].slot), int'(VECS[v].len), int'(VECS[v].hold), 0);
            stop = 1'b1;
            @(negedge clk);
            stop = 1'b0;
            check_idle("R7 stop");
        end

        // R6 and R10
        hold_clks = '0;
        send(3, 0);
        pulse_trigger();
        check("R3 slot 0 start", dac_out, wave(0, 0, 0));
        send(3, 1);
        check("R6 select leaves playback alone", dac_out, wave(0, 1, 0));
        pulse_trigger();
        check("R10 retrigger restarts", dac_out, wave(1, 0, 0));
        check("R10 playing", 16'(playing), 16'd1);

        // R9: write into the slot on air is held off
        send(0, 1);
        host_valid = 1'b1;
        host_kind  = 2'd2;
        host_data  = 16'hDEAD;
        #1;
        check("R9 ready low for live slot", 16'(host_ready), 16'd0);
        repeat (3) @(negedge clk);
        #1;
        check("R9 still held", 16'(host_ready), 16'd0);
        host_valid = 1'b0;
        @(negedge clk);
        load(2, 2, 5);
        check("R9 other slot accepted while playing", 16'(playing), 16'd1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        pulse_trigger();
        play_check(1, 3, 0, 0);
        send(3, 2);
        pulse_trigger();
        play_check(2, 2, 0, 5);

        // R2: extra sample words are dropped
        load(3, 3, 7);
        send(0, 3);
        send(1, 2);
        for (int i = 0; i < 3; i++) send(2, wave(3, i, 9));
        send(1, 3);
        send(3, 3);
        pulse_trigger();
        check("R2 point 0 rewritten", dac_out, wave(3, 0, 9));
        @(negedge clk);
        check("R2 point 1 rewritten", dac_out, wave(3, 1, 9));
        @(negedge clk);
        check("R2 overflow word dropped", dac_out, wave(3, 2, 7));
        @(negedge clk);
        check("R5 wrap to point 0", dac_out, wave(3, 0, 9));

        // R7: stop beats trigger
        trigger = 1'b1;
        stop    = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        stop    = 1'b0;
        check_idle("R7 stop wins over trigger");
        @(negedge clk);
        check_idle("R7 stays idle");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule